// File: doc/BRIEF.md
# TDM Slot Splitter with Auxiliary Stereo Re-serializer

This block takes a time-division multiplexed audio stream on a single data line. A bit-clock strobe marks each bit and a frame-sync input marks each frame. Every slot is 32 bits wide and carries a 24-bit word, MSB first. The first eight slots of each frame hold the on-chip playback channels. These are handed out as parallel words with a channel number and a one-cycle strobe. In long-frame mode the frame has sixteen slots. The four slots after the on-chip group are caught in a holding bank and replayed during the next frame on two stereo serial lines. The two lines share a framing clock and have their own bit-clock strobe.

Everything runs on one system clock. The TDM bit clock arrives as `tdm_tick` and the auxiliary bit clock as `aux_tick`, each a single-cycle enable. A frame controller walks five named states:
- `ST_HUNT`: waiting for a frame-sync rising edge.
- `ST_ONCHIP`: inside slots 0 to 7.
- `ST_AUXCAP`: inside slots 8 to 11 in long mode.
- `ST_UNUSED`: inside slots 12 to 15.
- `ST_WAITFS`: past the last bit of the frame, where the next tick must be a frame start.

The transitions are:
- Any state goes to `ST_ONCHIP` on a frame start.
- `ST_ONCHIP` goes to `ST_AUXCAP` at the end of slot 7 in long mode, or to `ST_WAITFS` in short mode.
- `ST_AUXCAP` goes to `ST_UNUSED` at the end of slot 11.
- `ST_UNUSED` goes to `ST_WAITFS` at the end of slot 15.
- `ST_WAITFS` goes to `ST_HUNT` on any tick that is not a frame start.

Top module: `tdm_aux_demux`

## Requirements
- R1: After reset `dac_valid`, `aux_lrclk` and both `aux_sd` bits are 0. They stay 0 while no frame start has been seen.
- R2: A frame start is a `tdm_tick` with `tdm_fsync` high when the previous tick sampled it low. That tick carries bit 0 of slot 0. Bits 1 to 24 of every slot are the word, MSB first. Bit 0 and bits 25 to 31 are ignored.
- R3: Each of slots 0 to 7 yields `dac_word` with `dac_chan` equal to the slot number (0=L1, 1=R1, 2=L2, 3=R2, 4=L3, 5=R3, 6=L4, 7=R4). `dac_valid` is a one-cycle pulse in the clock cycle after the tick that carries the slot's bit 24. Exactly eight pulses occur per frame.
- R4: `mode_long` is sampled only at a frame start. 1 selects a 16-slot (512-bit) frame and 0 selects an 8-slot (256-bit) frame. A change in mid-frame has no effect until the next frame start.
- R5: In long mode, slots 8 to 11 are captured for the auxiliary lines. Slots 12 to 15 produce no strobe and reach no output.
- R6: Words caught in one long frame play out during the next long frame. Line 0 (`aux_sd[0]`) carries slot 8 as left and slot 9 as right. Line 1 carries slot 10 as left and slot 11 as right. A 6-bit position counter is cleared at each frame start and advances on each `aux_tick`. `aux_lrclk` is 0 for positions 0 to 31 and 1 for positions 32 to 63. Positions 1 to 24 carry the left word MSB first, positions 33 to 56 carry the right word, and all other positions are 0.
- R7: Throughout a short-mode frame, `aux_lrclk` and `aux_sd` are held at 0. A long frame that does not follow a complete long frame sends zero words, while `aux_lrclk` still toggles.
- R8: If the tick after a frame's last bit is not a frame start, the block emits no strobes until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_tick | input | 1 | One-cycle enable per TDM bit |
| tdm_fsync | input | 1 | TDM frame sync, sampled on `tdm_tick` |
| tdm_sdata | input | 1 | TDM serial data, sampled on `tdm_tick` |
| mode_long | input | 1 | 1 = 16-slot frame with auxiliary lines, 0 = 8-slot frame |
| aux_tick | input | 1 | One-cycle enable per auxiliary bit |
| dac_word | output | 24 | Parallel word of the current on-chip slot |
| dac_chan | output | 3 | Slot number of `dac_word` |
| dac_valid | output | 1 | One-cycle strobe for `dac_word` and `dac_chan` |
| aux_lrclk | output | 1 | Shared auxiliary framing clock, low for left |
| aux_sd | output | 2 | Auxiliary serial data, one bit per stereo line |

## Verification
A slot counter that is off by one shifts every word by a bit. That shows as a wrong `dac_word` at the very first strobe of a frame, 25 ticks after the frame start. A controller stuck in the wrong state shows either as a missing or extra `dac_valid` pulse within the same frame, or as auxiliary data that is zero or stale during the following frame. A holding bank that keeps old words, or that loads the wrong slot, can only be seen one frame later. The bench therefore checks every auxiliary bit of every frame against the slots sent in the frame before.

// File: rtl/tdm_aux_pkg.sv
package tdm_aux_pkg;

    // Position of the frame controller within a TDM frame.
    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_ONCHIP = 3'd1,
        ST_AUXCAP = 3'd2,
        ST_UNUSED = 3'd3,
        ST_WAITFS = 3'd4
    } frame_state_t;

endpackage

// File: rtl/tdm_frame_fsm.sv
module tdm_frame_fsm
    import tdm_aux_pkg::*;
#(
    parameter int SLOT_BITS    = 32,
    parameter int ONCHIP_SLOTS = 8,
    parameter int AUX_SLOTS    = 4,
    parameter int LONG_SLOTS   = 16,
    parameter int CNT_W        = $clog2(LONG_SLOTS * SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fsync,
    input  logic             mode_long,
    output frame_state_t     state,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_start,
    output logic             long_q
);

    localparam int ONCHIP_LAST = ONCHIP_SLOTS * SLOT_BITS - 1;
    localparam int AUX_LAST    = (ONCHIP_SLOTS + AUX_SLOTS) * SLOT_BITS - 1;
    localparam int LONG_LAST   = LONG_SLOTS * SLOT_BITS - 1;

    frame_state_t     state_n;
    logic [CNT_W-1:0] cnt_n;
    logic             fs_prev;

    // Rising edge of frame sync, seen on a bit tick.
    always_comb begin
        frame_start = tick && fsync && !fs_prev;
    end

    // Next-state logic.
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (frame_start) begin
            state_n = ST_ONCHIP;
            cnt_n   = CNT_W'(1);
        end else if (tick) begin
            unique case (state)
                ST_HUNT: begin
                    state_n = ST_HUNT;
                end
                ST_ONCHIP: begin
                    cnt_n = cnt + CNT_W'(1);
                    if (cnt == CNT_W'(ONCHIP_LAST)) begin
                        state_n = long_q ? ST_AUXCAP : ST_WAITFS;
                    end
                end
                ST_AUXCAP: begin
                    cnt_n = cnt + CNT_W'(1);
                    if (cnt == CNT_W'(AUX_LAST)) begin
                        state_n = ST_UNUSED;
                    end
                end
                ST_UNUSED: begin
                    cnt_n = cnt + CNT_W'(1);
                    if (cnt == CNT_W'(LONG_LAST)) begin
                        state_n = ST_WAITFS;
                    end
                end
                ST_WAITFS: begin
                    state_n = ST_HUNT;
                end
                default: begin
                    state_n = ST_HUNT;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_HUNT;
            cnt     <= '0;
            fs_prev <= 1'b0;
            long_q  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (tick) begin
                fs_prev <= fsync;
            end
            if (frame_start) begin
                long_q <= mode_long;
            end
        end
    end

    // R2: a frame start always lands on slot 0, bit 1 next
    a_r2_start_enters_onchip: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state == ST_ONCHIP && cnt == CNT_W'(1)));

    // R4: on-chip region never runs past slot 7
    a_r4_onchip_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ONCHIP) |-> (cnt <= CNT_W'(ONCHIP_LAST)));

    // R4: a short frame never reaches the auxiliary region
    a_r4_short_skips_aux: assert property (@(posedge clk) disable iff (!rst_n)
        !long_q |-> (state != ST_AUXCAP && state != ST_UNUSED));

    // R8: a missing sync after the last bit drops to hunting
    a_r8_lost_sync_hunts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_WAITFS && !frame_start) |=> (state == ST_HUNT));

endmodule

// File: rtl/tdm_slot_shifter.sv
module tdm_slot_shifter
    import tdm_aux_pkg::*;
#(
    parameter int SLOT_BITS    = 32,
    parameter int WORD_BITS    = 24,
    parameter int ONCHIP_SLOTS = 8,
    parameter int AUX_SLOTS    = 4,
    parameter int CNT_W        = 9,
    parameter int CHAN_W       = $clog2(ONCHIP_SLOTS)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 tick,
    input  logic                                 sdata,
    input  logic                                 frame_start,
    input  frame_state_t                         state,
    input  logic [CNT_W-1:0]                     cnt,
    output logic [WORD_BITS-1:0]                 dac_word,
    output logic [CHAN_W-1:0]                    dac_chan,
    output logic                                 dac_valid,
    output logic [AUX_SLOTS-1:0][WORD_BITS-1:0]  aux_words
);

    localparam int POS_W  = $clog2(SLOT_BITS);
    localparam int SLOT_W = CNT_W - POS_W;

    logic [POS_W-1:0]     pos;
    logic [SLOT_W-1:0]    slot;
    logic [SLOT_W-1:0]    aux_off;
    logic [WORD_BITS-1:0] shreg;
    logic [WORD_BITS-1:0] full;
    logic                 word_end;

    always_comb begin
        pos      = cnt[POS_W-1:0];
        slot     = cnt[CNT_W-1:POS_W];
        aux_off  = slot - SLOT_W'(ONCHIP_SLOTS);
        full     = {shreg[WORD_BITS-2:0], sdata};
        word_end = tick && !frame_start && (pos == POS_W'(WORD_BITS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            dac_word  <= '0;
            dac_chan  <= '0;
            dac_valid <= 1'b0;
            aux_words <= '0;
        end else begin
            dac_valid <= 1'b0;
            if (tick) begin
                shreg <= full;
            end
            if (word_end && state == ST_ONCHIP) begin
                dac_valid <= 1'b1;
                dac_word  <= full;
                dac_chan  <= slot[CHAN_W-1:0];
            end
            for (int i = 0; i < AUX_SLOTS; i++) begin
                if (frame_start) begin
                    aux_words[i] <= '0;
                end else if (word_end && state == ST_AUXCAP && aux_off == SLOT_W'(i)) begin
                    aux_words[i] <= full;
                end
            end
        end
    end

    // R3: strobe lasts exactly one cycle
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    // R3/R5: strobes only come from the on-chip slot region
    a_r5_strobe_onchip_only: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> ($past(state) == ST_ONCHIP));

endmodule

// File: rtl/aux_frame_gen.sv
module aux_frame_gen #(
    parameter int AUX_FRAME_BITS = 64,
    parameter int ACNT_W         = $clog2(AUX_FRAME_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              load_en,
    input  logic              aux_tick,
    output logic [ACNT_W-1:0] acnt,
    output logic              aux_lrclk
);

    localparam logic [ACNT_W-1:0] HALF = ACNT_W'(AUX_FRAME_BITS / 2);

    logic en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acnt <= '0;
            en   <= 1'b0;
        end else if (frame_start) begin
            acnt <= '0;
            en   <= load_en;
        end else if (aux_tick) begin
            acnt <= acnt + ACNT_W'(1);
        end
    end

    always_comb begin
        aux_lrclk = en && (acnt >= HALF);
    end

    // R6: position advances by one per auxiliary tick
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_tick && !frame_start) |=> (acnt == $past(acnt) + ACNT_W'(1)));

    // R7: short frame keeps the framing clock low
    a_r7_short_lr_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !load_en) |=> !aux_lrclk);

endmodule

// File: rtl/aux_line_tx.sv
module aux_line_tx #(
    parameter int WORD_BITS      = 24,
    parameter int AUX_FRAME_BITS = 64,
    parameter int ACNT_W         = $clog2(AUX_FRAME_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 load_en,
    input  logic [WORD_BITS-1:0] left_in,
    input  logic [WORD_BITS-1:0] right_in,
    input  logic [ACNT_W-1:0]    acnt,
    output logic                 sd
);

    localparam logic [ACNT_W-1:0] HALF = ACNT_W'(AUX_FRAME_BITS / 2);

    logic [WORD_BITS-1:0] lw;
    logic [WORD_BITS-1:0] rw;
    logic [WORD_BITS-1:0] word;
    logic [WORD_BITS-1:0] shifted;
    logic [ACNT_W-1:0]    hpos;
    logic                 right;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lw <= '0;
            rw <= '0;
        end else if (frame_start) begin
            lw <= load_en ? left_in  : '0;
            rw <= load_en ? right_in : '0;
        end
    end

    always_comb begin
        right   = (acnt >= HALF);
        hpos    = right ? (acnt - HALF) : acnt;
        word    = right ? rw : lw;
        shifted = '0;
        sd      = 1'b0;
        if (hpos >= ACNT_W'(1) && hpos <= ACNT_W'(WORD_BITS)) begin
            shifted = word << (hpos - ACNT_W'(1));
            sd      = shifted[WORD_BITS-1];
        end
    end

    // R7: a short frame sends only zeros
    a_r7_short_data_low: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !load_en) |=> !sd);

endmodule

// File: rtl/tdm_aux_demux.sv
module tdm_aux_demux #(
    parameter int SLOT_BITS      = 32,
    parameter int WORD_BITS      = 24,
    parameter int ONCHIP_SLOTS   = 8,
    parameter int AUX_SLOTS      = 4,
    parameter int LONG_SLOTS     = 16,
    parameter int AUX_FRAME_BITS = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tdm_tick,
    input  logic                             tdm_fsync,
    input  logic                             tdm_sdata,
    input  logic                             mode_long,
    input  logic                             aux_tick,
    output logic [WORD_BITS-1:0]             dac_word,
    output logic [$clog2(ONCHIP_SLOTS)-1:0]  dac_chan,
    output logic                             dac_valid,
    output logic                             aux_lrclk,
    output logic [AUX_SLOTS/2-1:0]           aux_sd
);

    import tdm_aux_pkg::*;

    localparam int CNT_W     = $clog2(LONG_SLOTS * SLOT_BITS);
    localparam int CHAN_W    = $clog2(ONCHIP_SLOTS);
    localparam int ACNT_W    = $clog2(AUX_FRAME_BITS);
    localparam int AUX_LINES = AUX_SLOTS / 2;

    frame_state_t                       state;
    logic [CNT_W-1:0]                   cnt;
    logic                               frame_start;
    logic                               long_q;
    logic [AUX_SLOTS-1:0][WORD_BITS-1:0] aux_words;
    logic [ACNT_W-1:0]                  acnt;

    tdm_frame_fsm #(
        .SLOT_BITS    (SLOT_BITS),
        .ONCHIP_SLOTS (ONCHIP_SLOTS),
        .AUX_SLOTS    (AUX_SLOTS),
        .LONG_SLOTS   (LONG_SLOTS),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tdm_tick),
        .fsync       (tdm_fsync),
        .mode_long   (mode_long),
        .state       (state),
        .cnt         (cnt),
        .frame_start (frame_start),
        .long_q      (long_q)
    );

    tdm_slot_shifter #(
        .SLOT_BITS    (SLOT_BITS),
        .WORD_BITS    (WORD_BITS),
        .ONCHIP_SLOTS (ONCHIP_SLOTS),
        .AUX_SLOTS    (AUX_SLOTS),
        .CNT_W        (CNT_W),
        .CHAN_W       (CHAN_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tdm_tick),
        .sdata       (tdm_sdata),
        .frame_start (frame_start),
        .state       (state),
        .cnt         (cnt),
        .dac_word    (dac_word),
        .dac_chan    (dac_chan),
        .dac_valid   (dac_valid),
        .aux_words   (aux_words)
    );

    aux_frame_gen #(
        .AUX_FRAME_BITS (AUX_FRAME_BITS),
        .ACNT_W         (ACNT_W)
    ) u_auxgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .load_en     (mode_long),
        .aux_tick    (aux_tick),
        .acnt        (acnt),
        .aux_lrclk   (aux_lrclk)
    );

    for (genvar g = 0; g < AUX_LINES; g++) begin : g_line
        aux_line_tx #(
            .WORD_BITS      (WORD_BITS),
            .AUX_FRAME_BITS (AUX_FRAME_BITS),
            .ACNT_W         (ACNT_W)
        ) u_tx (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .load_en     (mode_long),
            .left_in     (aux_words[2*g]),
            .right_in    (aux_words[2*g+1]),
            .acnt        (acnt),
            .sd          (aux_sd[g])
        );
    end

    // R4: mode is only taken into the frame at its start
    a_r4_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(long_q));

endmodule

// File: tb/sim_tdm_aux_demux.sv
`timescale 1ns/1ps
module sim_tdm_aux_demux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tdm_tick = 1'b0;
    logic        tdm_fsync = 1'b0;
    logic        tdm_sdata = 1'b0;
    logic        mode_long = 1'b0;
    logic        aux_tick = 1'b0;
    logic [23:0] dac_word;
    logic [2:0]  dac_chan;
    logic        dac_valid;
    logic        aux_lrclk;
    logic [1:0]  aux_sd;

    int checks = 0;
    int errors = 0;
    int cur_f = 0;
    int exp_chan = 0;
    int strobes = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tdm_aux_demux u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tdm_tick  (tdm_tick),
        .tdm_fsync (tdm_fsync),
        .tdm_sdata (tdm_sdata),
        .mode_long (mode_long),
        .aux_tick  (aux_tick),
        .dac_word  (dac_word),
        .dac_chan  (dac_chan),
        .dac_valid (dac_valid),
        .aux_lrclk (aux_lrclk),
        .aux_sd    (aux_sd)
    );

    function automatic logic [23:0] wval(int f, int s);
        if (f == 2 && s == 0) return 24'hFFFFFF;
        if (f == 2 && s == 1) return 24'h000001;
        if (f == 1 && s == 8) return 24'h800000;
        if (f == 6 && s == 11) return 24'hFFFFFF;
        return 24'((f * 32'h0001_0203) ^ (s * 32'h0013_5791) ^ 32'h005A_A5C3);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R3: every strobe must carry the next channel of the current frame
    always @(negedge clk) begin
        if (rst_n && dac_valid) begin
            check(dac_chan == 3'(exp_chan) && dac_word == wval(cur_f, exp_chan), "R3",
                  {5'd0, dac_chan, dac_word}, {5'd0, 3'(exp_chan), wval(cur_f, exp_chan)});
            exp_chan++;
            strobes++;
        end
    end

    task automatic drive_tick(bit fs, bit d, bit a);
        @(negedge clk);
        tdm_tick  = 1'b1;
        tdm_fsync = fs;
        tdm_sdata = d;
        aux_tick  = a;
        @(negedge clk);
        tdm_tick  = 1'b0;
        aux_tick  = 1'b0;
    endtask

    task automatic run_frame(int f, bit long16, bit prev_ok, bit flip_mid);
        int n;
        int j;
        logic [23:0] lw [2];
        logic [23:0] rw [2];
        cur_f = f;
        exp_chan = 0;
        strobes = 0;
        mode_long = long16;
        n = long16 ? 512 : 256;
        j = 0;
        for (int l = 0; l < 2; l++) begin
            lw[l] = (prev_ok && long16) ? wval(f - 1, 8 + 2 * l) : 24'h0;
            rw[l] = (prev_ok && long16) ? wval(f - 1, 9 + 2 * l) : 24'h0;
        end
        for (int k = 0; k < n; k++) begin
            int slot;
            int pos;
            bit d;
            bit a;
            slot = k / 32;
            pos = k % 32;
            if (pos >= 1 && pos <= 24 && slot < 12) d = wval(f, slot)[24 - pos];
            else d = (((k * 5 + f) % 3) == 0);
            a = ((k % 8) == 4);
            if (flip_mid && k == 100) mode_long = ~long16;
            drive_tick(k < 32, d, a);
            if (a) begin
                int ac;
                int hp;
                bit elr;
                logic [1:0] esd;
                string tag;
                j++;
                ac = j % 64;
                hp = ac % 32;
                elr = long16 && (ac >= 32);
                for (int l = 0; l < 2; l++) begin
                    if (hp >= 1 && hp <= 24) esd[l] = (ac >= 32) ? rw[l][24 - hp] : lw[l][24 - hp];
                    else esd[l] = 1'b0;
                end
                tag = (long16 && prev_ok) ? "R6" : "R7";
                check({aux_lrclk, aux_sd} == {elr, esd}, tag,
                      {29'd0, aux_lrclk, aux_sd}, {29'd0, elr, esd});
            end
        end
        // R4 / R5: eight strobes, none from auxiliary or unused slots
        check(strobes == 8, long16 ? (flip_mid ? "R4" : "R5") : "R4", strobes, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({dac_valid, aux_lrclk, aux_sd} == 4'b0, "R1", {dac_valid, aux_lrclk, aux_sd}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 40; k++) drive_tick(1'b0, k[0], (k % 8) == 4);
        // R1: no frame start yet, outputs stay quiet
        check({aux_lrclk, aux_sd} == 3'b0 && strobes == 0, "R1", {aux_lrclk, aux_sd}, 0);
        // R2: frames with long and short framing
        run_frame(0, 1'b1, 1'b0, 1'b0);
        run_frame(1, 1'b1, 1'b1, 1'b1);
        run_frame(2, 1'b1, 1'b1, 1'b0);
        run_frame(3, 1'b0, 1'b1, 1'b0);
        run_frame(4, 1'b0, 1'b0, 1'b0);
        // R8: frame sync stops after a short frame
        strobes = 0;
        mode_long = 1'b1;
        for (int k = 0; k < 300; k++) drive_tick(1'b0, k[0], 1'b0);
        check(strobes == 0, "R8", strobes, 0);
        check({aux_lrclk, aux_sd} == 3'b0, "R8", {aux_lrclk, aux_sd}, 0);
        run_frame(5, 1'b1, 1'b0, 1'b0);
        run_frame(6, 1'b1, 1'b1, 1'b0);
        run_frame(7, 1'b1, 1'b1, 1'b0);
        run_frame(8, 1'b0, 1'b1, 1'b0);
        drive_tick(1'b0, 1'b0, 1'b0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule